// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command front end of an I2C master. Software writes 11-bit command words into a transmit queue through a small register port. Each word carries either a byte to send or a request to receive one byte, and two per-byte flags: a repeated START before the byte and a STOP after it. The sequencer takes words from the queue one at a time and hands each one to a bit-level bus engine through a request/done handshake. Received bytes are placed in a receive queue, and software reads them back through the same data/command register.

Two level flags with programmable thresholds let software keep the queues topped up or drained. A STOP travels only inside a command word. When the queue runs dry after a word without a STOP, the sequencer keeps the bus held and waits for the next word. An abort reported by the engine empties both queues. The target address and the 7/10-bit mode are locked while the block is enabled.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A register write to address 2 pushes `reg_wdata_i[10:0]` into the transmit queue as one command word (bit 8 = 1 read / 0 write, bit 9 = STOP after, bit 10 = repeated START before, bits 7:0 = write byte), and the transmit level at address 5 increases by one.
- R2: Each command taken from the queue raises `op_req_o`. `op_read_o`, `op_wdata_o` and `op_stop_o` carry bit 8, bits 7:0 and bit 9. Request and fields stay stable until `op_done_i`.
- R3: The first operation after the bus is idle has `op_start_o`=1. `op_restart_o` equals command bit 10 only when control bit 1 (restart enable) is set and the bus is already held. It is never set together with `op_start_o`.
- R4: A read completed without abort pushes `op_rdata_i` into the receive queue. A register read of address 2 pops it and returns the byte in bits 7:0, with the upper bits zero.
- R5: `tx_empty_o` is 1 exactly when the transmit level is at or below the threshold at address 3. `rx_full_o` is 1 exactly when the receive level is above the threshold at address 4, so a threshold of 0 flags the first byte.
- R6: When an operation without STOP completes and the queue is empty, `bus_hold_o` is 1 and no request is raised until a new command arrives.
- R7: A read command is not issued while the receive queue holds its full depth. It is issued once an entry has been popped.
- R8: A push to a full transmit queue is dropped and sets status bit 0. A pop of an empty receive queue returns 0 and sets status bit 1. Writing 1 to a status bit at address 7 clears it.
- R9: `op_done_i` together with `op_abort_i` empties both queues, sets status bit 2 and leaves the bus idle, so the next operation has `op_start_o`=1. A data push in that same cycle is dropped.
- R10: The target register at address 1 (bits 9:0 address, bit 12 = 10-bit mode) and control bit 2 (10-bit mode) change only while control bit 0 (enable) is 0. `op_addr_o` shows the address, and `op_addr10_o` is control bit 2 OR target bit 12.
- R11: While control bit 0 is 0, no command is taken from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops receive queue at address 2) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 13 | Register write data |
| reg_rdata_o | output | 13 | Register read data (combinational from address) |
| tx_empty_o | output | 1 | Transmit level at or below threshold |
| rx_full_o | output | 1 | Receive level above threshold |
| op_req_o | output | 1 | Byte operation requested from bus engine |
| op_read_o | output | 1 | Operation is a read |
| op_wdata_o | output | 8 | Byte to send |
| op_start_o | output | 1 | START needed before this byte |
| op_restart_o | output | 1 | Repeated START needed before this byte |
| op_stop_o | output | 1 | STOP after this byte |
| op_addr_o | output | 10 | Target address |
| op_addr10_o | output | 1 | 10-bit addressing |
| op_done_i | input | 1 | Engine finished current operation |
| op_abort_i | input | 1 | Operation ended with abort (valid with done) |
| op_rdata_i | input | 8 | Received byte (valid with done) |
| bus_hold_o | output | 1 | Bus held, waiting for next command |

## Verification
Two events can land on the same clock edge: an abort from the bus engine and a software push of a new command word. The bench lines them up by raising `op_done_i`, `op_abort_i` and the data-register write strobe on the same falling edge while the queue still holds several words. It then reads both level registers and the status register back. The flush must win, with both levels at zero and the pushed word gone. The next command must start a fresh transfer with a START.

// File: rtl/i2c_cmd_seq_pkg.sv
`timescale 1ns/1ps
package i2c_cmd_seq_pkg;
  localparam int CMD_W = 11;
  localparam int DW    = 13;
  localparam int AW    = 3;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_TARGET = 3'd1;
  localparam logic [AW-1:0] A_DATA   = 3'd2;
  localparam logic [AW-1:0] A_TXTHR  = 3'd3;
  localparam logic [AW-1:0] A_RXTHR  = 3'd4;
  localparam logic [AW-1:0] A_TXLVL  = 3'd5;
  localparam logic [AW-1:0] A_RXLVL  = 3'd6;
  localparam logic [AW-1:0] A_STAT   = 3'd7;

  localparam int C_READ    = 8;
  localparam int C_STOP    = 9;
  localparam int C_RESTART = 10;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BUSY, SEQ_HOLD} seq_state_e;
endpackage

// File: rtl/i2c_cmd_seq_fifo.sv
`timescale 1ns/1ps
module i2c_cmd_seq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_o == '0)); // R9
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (cnt_o == CNT_W'(DEPTH))); // R8
  AST_EMPTY_POP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (cnt_o == '0)); // R8
endmodule

// File: rtl/i2c_cmd_seq_ctrl.sv
`timescale 1ns/1ps
module i2c_cmd_seq_ctrl
  import i2c_cmd_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             restart_en_i,
  input  logic [CMD_W-1:0] tx_head_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  output logic             tx_pop_o,
  output logic             flush_o,
  output logic             rx_push_o,
  output logic             op_req_o,
  output logic             op_read_o,
  output logic [7:0]       op_wdata_o,
  output logic             op_start_o,
  output logic             op_restart_o,
  output logic             op_stop_o,
  input  logic             op_done_i,
  input  logic             op_abort_i,
  output logic             bus_hold_o
);
  seq_state_e state_q, state_d;
  logic       read_q, stop_q, start_q, restart_q;
  logic [7:0] wdata_q;
  logic       can_issue, done_ok;

  // a read waits for receive room; nothing moves while disabled
  assign can_issue = enable_i && !tx_empty_i && (state_q != SEQ_BUSY) &&
                     !(tx_head_i[C_READ] && rx_full_i);
  assign done_ok   = (state_q == SEQ_BUSY) && op_done_i;
  assign tx_pop_o  = can_issue;
  assign flush_o   = done_ok && op_abort_i;
  assign rx_push_o = done_ok && !op_abort_i && read_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE, SEQ_HOLD: if (can_issue) state_d = SEQ_BUSY;
      SEQ_BUSY: if (op_done_i) state_d = (op_abort_i || stop_q) ? SEQ_IDLE : SEQ_HOLD;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      read_q    <= 1'b0;
      stop_q    <= 1'b0;
      start_q   <= 1'b0;
      restart_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (can_issue) begin
        read_q    <= tx_head_i[C_READ];
        stop_q    <= tx_head_i[C_STOP];
        wdata_q   <= tx_head_i[7:0];
        start_q   <= (state_q == SEQ_IDLE);
        restart_q <= tx_head_i[C_RESTART] && restart_en_i && (state_q == SEQ_HOLD);
      end
    end
  end

  assign op_req_o     = (state_q == SEQ_BUSY);
  assign op_read_o    = read_q;
  assign op_wdata_o   = wdata_q;
  assign op_stop_o    = stop_q;
  assign op_start_o   = start_q;
  assign op_restart_o = restart_q;
  assign bus_hold_o   = (state_q == SEQ_HOLD);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o && !op_done_i) |=> (op_req_o && $stable(op_wdata_o) && $stable(op_read_o) && $stable(op_stop_o))); // R2
  AST_START_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> !(op_start_o && op_restart_o)); // R3
  AST_HOLD_AFTER_NOSTOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o && op_done_i && !op_abort_i && !op_stop_o) |=> bus_hold_o); // R6
  AST_READ_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (can_issue && tx_head_i[C_READ]) |=> !$past(rx_full_i)); // R7
  AST_NO_ISSUE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !op_req_o) |=> !op_req_o); // R11
endmodule

// File: rtl/i2c_cmd_seq.sv
`timescale 1ns/1ps
module i2c_cmd_seq
  import i2c_cmd_seq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          tx_empty_o,
  output logic          rx_full_o,
  output logic          op_req_o,
  output logic          op_read_o,
  output logic [7:0]    op_wdata_o,
  output logic          op_start_o,
  output logic          op_restart_o,
  output logic          op_stop_o,
  output logic [9:0]    op_addr_o,
  output logic          op_addr10_o,
  input  logic          op_done_i,
  input  logic          op_abort_i,
  input  logic [7:0]    op_rdata_i,
  output logic          bus_hold_o
);
  logic             en_q, rst_en_q, ctl_ten_q, tgt_ten_q;
  logic [9:0]       tgt_addr_q;
  logic [TX_CW-1:0] tx_thr_q, tx_cnt;
  logic [RX_CW-1:0] rx_thr_q, rx_cnt;
  logic             st_over_q, st_under_q, st_abort_q;

  logic [CMD_W-1:0] tx_head;
  logic [7:0]       rx_head;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_pop, rx_push, flush;
  logic wr_ctrl, wr_tgt, wr_stat;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_tgt  = reg_we_i && (reg_addr_i == A_TARGET);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign tx_push = reg_we_i && (reg_addr_i == A_DATA);
  assign rx_pop  = reg_re_i && (reg_addr_i == A_DATA);

  i2c_cmd_seq_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CMD_W)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .pop_i(tx_pop), .flush_i(flush),
    .wdata_i(reg_wdata_i[CMD_W-1:0]), .rdata_o(tx_head),
    .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  i2c_cmd_seq_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .pop_i(rx_pop), .flush_i(flush),
    .wdata_i(op_rdata_i), .rdata_o(rx_head),
    .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  i2c_cmd_seq_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .enable_i(en_q), .restart_en_i(rst_en_q),
    .tx_head_i(tx_head), .tx_empty_i(tx_empty), .rx_full_i(rx_full),
    .tx_pop_o(tx_pop), .flush_o(flush), .rx_push_o(rx_push),
    .op_req_o, .op_read_o, .op_wdata_o, .op_start_o, .op_restart_o, .op_stop_o,
    .op_done_i, .op_abort_i, .bus_hold_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      rst_en_q   <= 1'b0;
      ctl_ten_q  <= 1'b0;
      tgt_ten_q  <= 1'b0;
      tgt_addr_q <= '0;
      tx_thr_q   <= '0;
      rx_thr_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= reg_wdata_i[0];
        rst_en_q <= reg_wdata_i[1];
        if (!en_q) ctl_ten_q <= reg_wdata_i[2];
      end
      // addressing locked while enabled
      if (wr_tgt && !en_q) begin
        tgt_addr_q <= reg_wdata_i[9:0];
        tgt_ten_q  <= reg_wdata_i[12];
      end
      if (reg_we_i && reg_addr_i == A_TXTHR) tx_thr_q <= reg_wdata_i[TX_CW-1:0];
      if (reg_we_i && reg_addr_i == A_RXTHR) rx_thr_q <= reg_wdata_i[RX_CW-1:0];
    end
  end

  // sticky error flags, write-one-to-clear; a new event wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_over_q  <= 1'b0;
      st_under_q <= 1'b0;
      st_abort_q <= 1'b0;
    end else begin
      st_over_q  <= (tx_push && tx_full && !flush) ||
                    (st_over_q && !(wr_stat && reg_wdata_i[0]));
      st_under_q <= (rx_pop && rx_empty && !flush) ||
                    (st_under_q && !(wr_stat && reg_wdata_i[1]));
      st_abort_q <= flush || (st_abort_q && !(wr_stat && reg_wdata_i[2]));
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = DW'({ctl_ten_q, rst_en_q, en_q});
      A_TARGET: reg_rdata_o = {tgt_ten_q, 2'b00, tgt_addr_q};
      A_DATA:   reg_rdata_o = rx_empty ? '0 : DW'(rx_head);
      A_TXTHR:  reg_rdata_o = DW'(tx_thr_q);
      A_RXTHR:  reg_rdata_o = DW'(rx_thr_q);
      A_TXLVL:  reg_rdata_o = DW'(tx_cnt);
      A_RXLVL:  reg_rdata_o = DW'(rx_cnt);
      A_STAT:   reg_rdata_o = DW'({st_abort_q, st_under_q, st_over_q});
      default:  reg_rdata_o = '0;
    endcase
  end

  assign tx_empty_o  = (tx_cnt <= tx_thr_q);
  assign rx_full_o   = (rx_cnt > rx_thr_q);
  assign op_addr_o   = tgt_addr_q;
  assign op_addr10_o = ctl_ten_q || tgt_ten_q;

  AST_TARGET_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> ($stable(tgt_addr_q) && $stable(tgt_ten_q) && $stable(ctl_ten_q))); // R10
  AST_ABORT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o && op_done_i && op_abort_i) |=> (st_abort_q && !op_req_o && !bus_hold_o)); // R9
  AST_RX_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o && op_done_i && !op_abort_i && op_read_o && !rx_pop && !rx_full) |=> (rx_cnt != '0)); // R4
endmodule

// File: tb/test_i2c_cmd_seq.sv
`timescale 1ns/1ps
module test_i2c_cmd_seq;
  import i2c_cmd_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [12:0] reg_wdata_i = '0;
  logic [12:0] reg_rdata_o;
  logic        tx_empty_o, rx_full_o, op_req_o, op_read_o, op_start_o, op_restart_o, op_stop_o;
  logic [7:0]  op_wdata_o;
  logic [9:0]  op_addr_o;
  logic        op_addr10_o, bus_hold_o;
  logic        op_done_i = 1'b0, op_abort_i = 1'b0;
  logic [7:0]  op_rdata_i = '0;

  int checks = 0;
  int fails = 0;
  logic       c_read, c_stop, c_start, c_restart, c_addr10;
  logic [7:0] c_wdata;
  logic [9:0] c_addr;
  logic [12:0] rv;

  // {cmd[10:0], expected start, expected restart}; restart enabled, bus idle at entry 0
  localparam logic [12:0] VEC [6] = '{
    {11'h05A, 1'b1, 1'b0},
    {11'h4A5, 1'b0, 1'b1},
    {11'h100, 1'b0, 1'b0},
    {11'h300, 1'b0, 1'b0},
    {11'h43C, 1'b1, 1'b0},
    {11'h611, 1'b0, 1'b1}
  };

  always #4 clk = ~clk;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .tx_empty_o, .rx_full_o,
    .op_req_o, .op_read_o, .op_wdata_o, .op_start_o, .op_restart_o, .op_stop_o,
    .op_addr_o, .op_addr10_o, .op_done_i, .op_abort_i, .op_rdata_i, .bus_hold_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [12:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [12:0] d);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_re_i = 1'b0;
  endtask

  task automatic serve(input logic [7:0] rdata, input logic abort, input logic push,
                       input logic [10:0] pcmd);
    int n = 0;
    while (!op_req_o && n < 200) begin @(negedge clk); n++; end
    if (!op_req_o) chk("R2 request never raised", 0, 1);
    c_read = op_read_o; c_stop = op_stop_o; c_start = op_start_o;
    c_restart = op_restart_o; c_wdata = op_wdata_o; c_addr = op_addr_o; c_addr10 = op_addr10_o;
    op_done_i = 1'b1; op_abort_i = abort; op_rdata_i = rdata;
    if (push) begin reg_we_i = 1'b1; reg_addr_i = A_DATA; reg_wdata_i = {2'b00, pcmd}; end
    @(negedge clk);
    op_done_i = 1'b0; op_abort_i = 1'b0; reg_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("reset op_req", op_req_o, 0);
    chk("reset bus_hold", bus_hold_o, 0);
    chk("R5 reset tx_empty", tx_empty_o, 1);
    chk("R5 reset rx_full", rx_full_o, 0);
    rd(A_TXLVL, rv); chk("reset txlvl", rv, 0);

    // disabled: target programming, queueing, thresholds, overflow
    wr(A_TARGET, 13'h1123);
    rd(A_TARGET, rv); chk("R10 target readback", rv, 13'h1123);
    wr(A_DATA, 13'h100); wr(A_DATA, 13'h100); wr(A_DATA, 13'h005);
    rd(A_TXLVL, rv); chk("R1 txlvl after 3 pushes", rv, 3);
    repeat (5) @(negedge clk);
    chk("R11 no request while disabled", op_req_o, 0);
    chk("R5 tx_empty lvl3 thr0", tx_empty_o, 0);
    wr(A_TXTHR, 13'd3); chk("R5 tx_empty lvl3 thr3", tx_empty_o, 1);
    wr(A_TXTHR, 13'd2); chk("R5 tx_empty lvl3 thr2", tx_empty_o, 0);
    for (int i = 0; i < 5; i++) wr(A_DATA, 13'h005);
    wr(A_DATA, 13'h0FF);
    rd(A_TXLVL, rv); chk("R8 txlvl stays full", rv, 8);
    rd(A_STAT, rv); chk("R8 overflow flag", rv, 13'h001);
    wr(A_STAT, 13'h007);
    rd(A_STAT, rv); chk("R8 status cleared", rv, 0);

    // enable; first read completes, second aborts with a push in the same cycle
    wr(A_CTRL, 13'h001);
    serve(8'h77, 1'b0, 1'b0, 11'h0);
    chk("R3 first op start", c_start, 1);
    chk("R2 first op is read", c_read, 1);
    chk("R10 op address", c_addr, 10'h123);
    chk("R10 op 10-bit mode", c_addr10, 1);
    rd(A_RXLVL, rv); chk("R4 rx level after read", rv, 1);
    chk("R5 rx_full thr0 first byte", rx_full_o, 1);
    serve(8'h88, 1'b1, 1'b1, 11'h2AA);
    rd(A_TXLVL, rv); chk("R9 tx flushed, push dropped", rv, 0);
    rd(A_RXLVL, rv); chk("R9 rx flushed", rv, 0);
    rd(A_STAT, rv); chk("R9 abort flag", rv, 13'h004);
    chk("R9 bus idle after abort", bus_hold_o, 0);
    wr(A_TARGET, 13'h0055);
    rd(A_TARGET, rv); chk("R10 target locked while enabled", rv, 13'h1123);
    wr(A_STAT, 13'h007);
    wr(A_DATA, 13'h2AA);
    serve(8'h00, 1'b0, 1'b0, 11'h0);
    chk("R9 start after abort", c_start, 1);
    chk("R2 stop and data", {c_stop, c_wdata}, {1'b1, 8'hAA});

    // table walk with restart enabled
    wr(A_CTRL, 13'h003);
    for (int i = 0; i < 6; i++) begin
      wr(A_DATA, {2'b00, VEC[i][12:2]});
      serve(8'hC0 | 8'(i), 1'b0, 1'b0, 11'h0);
      chk("R2 fields", {c_read, c_stop, c_wdata},
          {VEC[i][C_READ+2], VEC[i][C_STOP+2], (VEC[i][C_READ+2] ? 8'h00 : VEC[i][9:2])});
      chk("R3 start/restart", {c_start, c_restart}, {VEC[i][1], VEC[i][0]});
      if (i == 0) begin
        repeat (3) @(negedge clk);
        chk("R6 bus held after no-stop", bus_hold_o, 1);
        chk("R6 no request while held", op_req_o, 0);
      end
      if (i == 3) chk("R6 bus released after stop", bus_hold_o, 0);
    end
    chk("R5 rx_full lvl2 thr0", rx_full_o, 1);
    wr(A_RXTHR, 13'd2); chk("R5 rx_full lvl2 thr2", rx_full_o, 0);
    wr(A_RXTHR, 13'd0);
    rd(A_DATA, rv); chk("R4 first received byte", rv, 13'h0C2);
    rd(A_DATA, rv); chk("R4 second received byte", rv, 13'h0C3);
    rd(A_DATA, rv); chk("R8 empty pop returns 0", rv, 0);
    rd(A_STAT, rv); chk("R8 underflow flag", rv, 13'h002);
    wr(A_STAT, 13'h007);

    // receive queue full blocks the next read
    for (int i = 0; i < 8; i++) begin
      wr(A_DATA, 13'h100);
      serve(8'(i), 1'b0, 1'b0, 11'h0);
    end
    rd(A_RXLVL, rv); chk("R7 rx queue full", rv, 8);
    wr(A_DATA, 13'h300);
    repeat (6) @(negedge clk);
    chk("R7 read held back", op_req_o, 0);
    rd(A_TXLVL, rv); chk("R7 command still queued", rv, 1);
    rd(A_DATA, rv); chk("R7 pop frees room", rv, 0);
    serve(8'h5E, 1'b0, 1'b0, 11'h0);
    chk("R7 read issued after pop", {c_read, c_stop}, 2'b11);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule